// File: doc/BRIEF.md
# Ordered Task Doorbell

This block keeps the pending-task register of a storage command-queue engine, with one bit for each of 32 task slots. Software submits tasks by writing a mask in which each 1 bit sets the matching slot. The block records the order in which slots were submitted and offers them one at a time, oldest first, to a downstream command issuer through a valid/ready handshake.

A slot's pending bit stays set after dispatch until the issuer reports completion. A per-task clear mask, a clear-all pulse or dropping the engine enable also retire slots. A retired slot is withdrawn from the submission order at once, so it is never offered afterwards. When direct-command mode is on, slot 31 is reserved for a direct command, and its dispatch carries a flag that tells the issuer it is not a data transfer.

The dispatch port is a stream. `disp_valid` is high while at least one submitted slot waits and the engine is enabled. `disp_idx` and `disp_dcmd` hold steady while `disp_ready` is low, unless a clear removes the head slot. A slot is consumed on a clock edge where valid and ready are both high. The issuer may hold ready low for any length of time, and no submission is lost while it does.

Top module: `task_doorbell`

## Requirements
- R1: After reset, `pend` is all zeros and `disp_valid` is low.
- R2: A doorbell write sets `pend[n]` for each 1 bit n of `wr_mask` from the next cycle. A 0 bit leaves its slot unchanged, so a write of all zeros changes nothing.
- R3: Slots set by different writes are dispatched in the order of those writes, whatever their slot numbers.
- R4: Slots set by a single write are dispatched in ascending slot order, lowest first.
- R5: Writing 1 to a slot that is already pending is ignored, and the slot is dispatched only once.
- R6: A completion on `cpl_idx` clears that slot's pending bit. If a completion and a new write for the same slot arrive in the same cycle, the slot ends up pending and is queued behind every slot already waiting.
- R7: A 1 in `clr_mask` clears that slot's pending bit and withdraws the slot from dispatch.
- R8: A `clr_all` pulse clears every pending bit and withdraws every slot from dispatch. A write in the same cycle is applied after the clear.
- R9: While `eng_en` is low, all pending bits are cleared, `disp_valid` is low and writes are ignored. Writes are also ignored while `cfg_ok` is low.
- R10: `disp_dcmd` is 1 exactly when `dcmd_en` is 1 and `disp_idx` is 31. Otherwise it is 0.
- R11: While `disp_valid` is high and `disp_ready` is low, `disp_idx` stays unchanged as long as no clear, completion or disable affects the slots. Each submission yields exactly one dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eng_en | input | 1 | Engine enable; low clears all slots |
| cfg_ok | input | 1 | Task list base address configured |
| dcmd_en | input | 1 | Direct-command mode; reserves slot 31 |
| wr_en | input | 1 | Doorbell write strobe |
| wr_mask | input | 32 | Write-1-to-set slot mask |
| cpl_valid | input | 1 | Task completion strobe |
| cpl_idx | input | 5 | Slot that completed |
| clr_mask | input | 32 | Per-task clear mask (1 clears the slot) |
| clr_all | input | 1 | Clear-all-tasks pulse |
| pend | output | 32 | Pending slot bits |
| disp_valid | output | 1 | A submitted slot is offered |
| disp_ready | input | 1 | Issuer accepts the offered slot |
| disp_idx | output | 5 | Offered slot index |
| disp_dcmd | output | 1 | Offered slot is a direct command |

## Verification
A corrupt ordering relation shows up on the first dispatch that follows it: `disp_idx` names a slot out of submission order, either across writes or inside one batch. A stale queue entry appears as a dispatch with no matching submission, or as a slot offered again after it was cleared, and this shows within one cycle of the issuer raising ready. Wrong clear handling shows on `pend` one cycle after the clear. A missed withdrawal shows as `disp_valid` staying high after the last live slot is gone.

// File: rtl/tdb_pkg.sv
package tdb_pkg;
  parameter int unsigned TDB_SLOTS = 32;
  parameter int unsigned TDB_IDX_W = $clog2(TDB_SLOTS);
endpackage

// File: rtl/tdb_pending.sv
// Pending-bit register: clears are applied first, then the gated write.
module tdb_pending #(
  parameter int unsigned N = 32,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eng_en,
  input  logic          cfg_ok,
  input  logic          wr_en,
  input  logic [N-1:0]  wr_mask,
  input  logic          cpl_valid,
  input  logic [IW-1:0] cpl_idx,
  input  logic [N-1:0]  clr_mask,
  input  logic          clr_all,
  output logic [N-1:0]  pend,
  output logic [N-1:0]  set_new,
  output logic [N-1:0]  rm
);
  logic [N-1:0] cpl_hot;
  logic [N-1:0] survive;
  logic         wr_ok;

  always_comb begin
    cpl_hot = cpl_valid ? (N'(1) << cpl_idx) : '0;
    rm      = cpl_hot | clr_mask | {N{clr_all | ~eng_en}};
    survive = pend & ~rm;
    wr_ok   = wr_en & eng_en & cfg_ok;
    set_new = wr_ok ? (wr_mask & ~survive) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= survive | set_new;
  end
endmodule

// File: rtl/tdb_order.sv
// Submission order kept as an age matrix: older[r][c] = slot r was queued before slot c.
module tdb_order #(
  parameter int unsigned N = 32,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  set_new,
  input  logic [N-1:0]  rm,
  input  logic [N-1:0]  pop,
  output logic          any_q,
  output logic [N-1:0]  head,
  output logic [IW-1:0] head_idx
);
  logic [N-1:0] queued;
  logic [N-1:0] older [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) queued <= '0;
    else        queued <= (queued & ~rm & ~pop) | set_new;
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) older[r][c] <= 1'b0;
        else if (set_new[c]) older[r][c] <= set_new[r] ? (r < c) : 1'b1;
        else if (set_new[r]) older[r][c] <= 1'b0;
      end
    end
  end

  always_comb begin
    any_q = |queued;
    for (int c = 0; c < N; c++) begin
      logic beaten;
      beaten = 1'b0;
      for (int r = 0; r < N; r++) beaten |= queued[r] & older[r][c];
      head[c] = queued[c] & ~beaten;
    end
    head_idx = '0;
    for (int c = 0; c < N; c++) if (head[c]) head_idx |= IW'(c);
  end
endmodule

// File: rtl/task_doorbell.sv
module task_doorbell
  import tdb_pkg::*;
#(
  parameter int unsigned N_SLOTS = TDB_SLOTS,
  localparam int unsigned IW = $clog2(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               eng_en,
  input  logic               cfg_ok,
  input  logic               dcmd_en,
  input  logic               wr_en,
  input  logic [N_SLOTS-1:0] wr_mask,
  input  logic               cpl_valid,
  input  logic [IW-1:0]      cpl_idx,
  input  logic [N_SLOTS-1:0] clr_mask,
  input  logic               clr_all,
  output logic [N_SLOTS-1:0] pend,
  output logic               disp_valid,
  input  logic               disp_ready,
  output logic [IW-1:0]      disp_idx,
  output logic               disp_dcmd
);
  localparam logic [IW-1:0] DCMD_SLOT = IW'(N_SLOTS - 1);

  logic [N_SLOTS-1:0] set_new, rm, head, pop;
  logic               any_q;

  tdb_pending #(.N(N_SLOTS), .IW(IW)) u_pend (
    .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .cfg_ok(cfg_ok),
    .wr_en(wr_en), .wr_mask(wr_mask), .cpl_valid(cpl_valid),
    .cpl_idx(cpl_idx), .clr_mask(clr_mask), .clr_all(clr_all),
    .pend(pend), .set_new(set_new), .rm(rm)
  );

  tdb_order #(.N(N_SLOTS), .IW(IW)) u_order (
    .clk(clk), .rst_n(rst_n), .set_new(set_new), .rm(rm), .pop(pop),
    .any_q(any_q), .head(head), .head_idx(disp_idx)
  );

  always_comb begin
    disp_valid = any_q & eng_en;
    pop        = (disp_valid & disp_ready) ? head : '0;
    disp_dcmd  = dcmd_en & (disp_idx == DCMD_SLOT);
  end
endmodule

// File: rtl/tdb_checker.sv
module tdb_checker #(
  parameter int unsigned N = 32,
  parameter int unsigned IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eng_en,
  input logic          cfg_ok,
  input logic          dcmd_en,
  input logic          wr_en,
  input logic          clr_all,
  input logic [N-1:0]  pend,
  input logic          disp_valid,
  input logic [IW-1:0] disp_idx,
  input logic          disp_dcmd
);
  // R10: direct-command flag only on the reserved slot in that mode
  a_r10_dcmd_slot: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && disp_dcmd |-> dcmd_en && disp_idx == IW'(N - 1));

  // R11: an offered slot is always a pending one
  a_r11_offer_pending: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> pend[disp_idx]);

  // R9: disable empties the register and blocks dispatch
  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_en |=> pend == '0);
  a_r9_no_offer_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_en |-> !disp_valid);

  // R8: clear-all with no write empties the register
  a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all && !wr_en |=> pend == '0);

  // R2: no bit rises without a write strobe
  a_r2_rise_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (pend & ~$past(pend)) == '0);

  // R9: writes gated by missing configuration
  a_r9_cfg_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ok |=> (pend & ~$past(pend)) == '0);
endmodule

bind task_doorbell tdb_checker #(.N(N_SLOTS), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .cfg_ok(cfg_ok),
  .dcmd_en(dcmd_en), .wr_en(wr_en), .clr_all(clr_all), .pend(pend),
  .disp_valid(disp_valid), .disp_idx(disp_idx), .disp_dcmd(disp_dcmd)
);

// File: tb/tb_task_doorbell.sv
module tb_task_doorbell;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eng_en = 1'b1, cfg_ok = 1'b1, dcmd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_mask = '0;
  logic        cpl_valid = 1'b0;
  logic [4:0]  cpl_idx = '0;
  logic [31:0] clr_mask = '0;
  logic        clr_all = 1'b0;
  logic [31:0] pend;
  logic        disp_valid, disp_ready = 1'b0, disp_dcmd;
  logic [4:0]  disp_idx;

  int checks = 0;
  int errors = 0;
  int exp_q[$];

  always #5 clk = ~clk;

  task_doorbell dut (
    .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .cfg_ok(cfg_ok),
    .dcmd_en(dcmd_en), .wr_en(wr_en), .wr_mask(wr_mask),
    .cpl_valid(cpl_valid), .cpl_idx(cpl_idx), .clr_mask(clr_mask),
    .clr_all(clr_all), .pend(pend), .disp_valid(disp_valid),
    .disp_ready(disp_ready), .disp_idx(disp_idx), .disp_dcmd(disp_dcmd)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: compare each accepted dispatch with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && disp_valid && disp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11: actual unexpected dispatch of slot %0d expected none", disp_idx);
      end else begin
        int e;
        e = exp_q.pop_front();
        check("R3/R4 dispatch order", 32'(disp_idx), 32'(e));
        check("R10 dcmd flag", 32'(disp_dcmd), 32'(dcmd_en && e == 31));
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_write(logic [31:0] m);
    wr_en = 1'b1; wr_mask = m; step(); wr_en = 1'b0; wr_mask = '0;
  endtask

  task automatic do_cpl(int idx);
    cpl_valid = 1'b1; cpl_idx = 5'(idx); step(); cpl_valid = 1'b0;
  endtask

  task automatic drain(string req);
    int n = 0;
    disp_ready = 1'b1;
    while (exp_q.size() != 0 && n < 200) begin step(); n++; end
    disp_ready = 1'b0;
    check({req, " scoreboard drained"}, 32'(exp_q.size()), 0);
    exp_q.delete();
    step();
    @(negedge clk);
    check({req, " no extra dispatch"}, 32'(disp_valid), 0);
    step();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 pend reset", pend, 0);
    check("R1 valid reset", 32'(disp_valid), 0);
    rst_n = 1'b1;
    step();

    // R2 R3 R4 R5: two writes, out of index order, plus a zero write and a rewrite
    exp_q.push_back(5); exp_q.push_back(7); exp_q.push_back(1); exp_q.push_back(2);
    do_write(32'h0000_00A0);
    do_write(32'h0000_0006);
    @(negedge clk); check("R2 set bits", pend, 32'h0000_00A6);
    step();
    do_write(32'h0000_0000);
    @(negedge clk); check("R2 zero write", pend, 32'h0000_00A6);
    step();
    do_write(32'h0000_0020); // R5 slot 5 already pending
    @(negedge clk); check("R5 rewrite pend", pend, 32'h0000_00A6);
    step();
    drain("R3 R5");
    check("R6 pend held after dispatch", pend, 32'h0000_00A6);
    do_cpl(5);
    @(negedge clk); check("R6 completion clears", pend, 32'h0000_0086);
    step();
    do_cpl(7); do_cpl(1); do_cpl(2);
    @(negedge clk); check("R6 all completed", pend, 0);
    step();

    // R7: per-task clear withdraws slot 4
    exp_q.push_back(3); exp_q.push_back(9);
    do_write(32'h0000_0218);
    clr_mask = 32'h0000_0010; step(); clr_mask = '0;
    @(negedge clk); check("R7 clear mask", pend, 32'h0000_0208);
    step();
    drain("R7");
    do_cpl(3); do_cpl(9);

    // R8: clear-all
    do_write(32'h0000_0C00);
    clr_all = 1'b1; step(); clr_all = 1'b0;
    @(negedge clk);
    check("R8 clear all pend", pend, 0);
    check("R8 clear all valid", 32'(disp_valid), 0);
    step();

    // R6: completion and re-set of slot 12 in one cycle
    exp_q.push_back(12); exp_q.push_back(13);
    do_write(32'h0000_1000);
    do_write(32'h0000_2000);
    drain("R3");
    exp_q.push_back(14); exp_q.push_back(12);
    do_write(32'h0000_4000);
    cpl_valid = 1'b1; cpl_idx = 5'd12; wr_en = 1'b1; wr_mask = 32'h0000_1000;
    step();
    cpl_valid = 1'b0; wr_en = 1'b0; wr_mask = '0;
    @(negedge clk); check("R6 same-cycle re-set", pend, 32'h0000_7000);
    step();
    drain("R6");
    do_cpl(12); do_cpl(13); do_cpl(14);

    // R11: offer held under back-pressure
    do_write(32'h0000_0040);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R11 valid held", 32'(disp_valid), 1);
      check("R11 idx held", 32'(disp_idx), 6);
      step();
    end
    exp_q.push_back(6);
    drain("R11");
    do_cpl(6);

    // R9: disable clears and withdraws; gated writes ignored
    do_write(32'h0010_0000);
    eng_en = 1'b0; step();
    @(negedge clk); check("R9 disable clears", pend, 0);
    check("R9 disabled valid", 32'(disp_valid), 0);
    step();
    do_write(32'h0000_0100);
    @(negedge clk); check("R9 write while disabled", pend, 0);
    step();
    eng_en = 1'b1; step();
    @(negedge clk); check("R9 withdrawn after re-enable", 32'(disp_valid), 0);
    step();
    cfg_ok = 1'b0;
    do_write(32'h0020_0000);
    @(negedge clk); check("R9 write without config", pend, 0);
    step();
    cfg_ok = 1'b1;

    // R10: direct command on slot 31, batch ordering with slot 0
    dcmd_en = 1'b1;
    exp_q.push_back(0); exp_q.push_back(31);
    do_write(32'h8000_0001);
    drain("R10 R4");
    do_cpl(0); do_cpl(31);
    dcmd_en = 1'b0;
    exp_q.push_back(31);
    do_write(32'h8000_0000);
    drain("R10 off");
    do_cpl(31);
    @(negedge clk); check("R6 final pend", pend, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule